// File: doc/BRIEF.md
# Shift-Add Multiplier Control Sequencer

This block is the control unit of a sequential shift-and-add multiplier. The datapath is kept outside it. The sequencer reads three status inputs: a start request, a flag that says the bit counter has reached zero, and the current low bit of the multiplier register. From these it issues four strobes to the datapath:

- an initialise strobe, which clears the accumulator and presets the counter;
- a conditional add strobe;
- a carry-clear strobe;
- a shift-and-decrement strobe.

A multiply passes through three states:

- **Wait**: waiting for a request.
- **Add**: the add of the multiplicand is made when the low multiplier bit is 1.
- **Shift**: the partial product is shifted right and the counter is decremented.

The add and shift states repeat until the counter flag is seen in the shift state.

A single parameter selects how the state is held. The first variant keeps a two-bit binary code and decodes it into three state lines. The second keeps one flip-flop per state, with demultiplexer-style decision terms merged by OR gates. Both variants expose the same ports and produce the same outputs and decoded state every cycle.

In either variant, an unreachable state pattern falls back to the wait state on the next clock.

Top module: `mulseq_ctrl`

## Requirements
- R1: While reset is low, the state is the wait state. The decoded state output `dec_state` is one-hot in every cycle, with bit 0 = wait, bit 1 = add and bit 2 = shift. In the wait state with `go` = 0, all four strobes are 0.
- R2: In the wait state with `go` = 0, the block stays in the wait state on the next clock and asserts no strobe.
- R3: In the wait state with `go` = 1, `init_o` and `clr_carry_o` are 1 in that same cycle, and the next state is the add state.
- R4: `load_o` equals `mbit0` in the add state and is 0 in every other state.
- R5: In the shift state, `shift_dec_o` and `clr_carry_o` are 1. The next state is the add state when `cnt_zero` = 0 and the wait state when `cnt_zero` = 1. Outside the shift state, `shift_dec_o` is 0.
- R6: The add state always goes to the shift state on the next clock, whatever the values of `go`, `cnt_zero` and `mbit0`. `mbit0` never changes the next state in any state.
- R7: With `ONE_HOT` = 0 (binary code) and `ONE_HOT` = 1 (one flip-flop per state), the four strobes and `dec_state` are identical on every cycle for the same input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request |
| cnt_zero | input | 1 | Bit counter has reached zero |
| mbit0 | input | 1 | Current low bit of the multiplier register |
| dec_state | output | 3 | Decoded state, one-hot: bit 0 = wait, bit 1 = add, bit 2 = shift |
| init_o | output | 1 | Initialise accumulator and counter |
| load_o | output | 1 | Load the adder result into the accumulator |
| clr_carry_o | output | 1 | Clear the carry flip-flop |
| shift_dec_o | output | 1 | Shift the product right and decrement the counter |

## Verification
Both variants run side by side on the same long pseudo-random sequence of `go`, `cnt_zero` and `mbit0`. The `cnt_zero` input is biased low, so that add/shift loops of varying length occur. A reference state model is updated arithmetically in the bench.

Patterns with `go` held low in the wait state tell holding apart from starting. Toggling `cnt_zero` in the shift state tells the loop-back path from the exit path. Flipping `mbit0` in every state shows that it gates only the add strobe, and only in the add state. Comparing the two variants every cycle separates a fault in the binary decode from one in the per-state flip-flop network.

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       cnt_zero,
  input  logic       mbit0,
  output logic [2:0] dec_state,
  output logic       init_o,
  output logic       load_o,
  output logic       clr_carry_o,
  output logic       shift_dec_o
);
  logic st_idle, st_add, st_shift;
  logic start, shift_loop, shift_done, idle_stay;

  assign start      = st_idle & go;
  assign idle_stay  = st_idle & ~go;
  assign shift_loop = st_shift & ~cnt_zero;
  assign shift_done = st_shift & cnt_zero;

  generate
    if (!ONE_HOT) begin : g_enc
      logic [1:0] code_q, code_d;
      assign code_d = {st_add, start | shift_loop};
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) code_q <= 2'b00;
        else        code_q <= code_d;
      assign st_idle  = (code_q == 2'b00);
      assign st_add   = (code_q == 2'b01);
      assign st_shift = (code_q == 2'b10);
    end else begin : g_ohot
      logic [2:0] ff_q;
      logic       legal;
      assign legal = (ff_q == 3'b001) | (ff_q == 3'b010) | (ff_q == 3'b100);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      ff_q <= 3'b001;
        else if (!legal) ff_q <= 3'b001;
        else             ff_q <= {st_add, start | shift_loop, idle_stay | shift_done};
      assign st_idle  = ff_q[0] & legal;
      assign st_add   = ff_q[1] & legal;
      assign st_shift = ff_q[2] & legal;
    end
  endgenerate

  assign dec_state   = {st_shift, st_add, st_idle};
  assign init_o      = start;
  assign load_o      = st_add & mbit0;
  assign clr_carry_o = start | st_shift;
  assign shift_dec_o = st_shift;
endmodule

module mulseq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       cnt_zero,
  input logic       mbit0,
  input logic [2:0] dec_state,
  input logic       init_o,
  input logic       load_o,
  input logic       clr_carry_o,
  input logic       shift_dec_o
);
  assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_state) == 1);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[0] && !go |=> dec_state[0]);
  assert_start_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[0] && go |-> init_o && clr_carry_o);
  assert_start_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[0] && go |=> dec_state[1]);
  assert_load_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> dec_state[1] && mbit0);
  assert_shift_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[2] && !cnt_zero |=> dec_state[1]);
  assert_shift_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[2] && cnt_zero |=> dec_state[0]);
  assert_shift_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_dec_o |-> dec_state[2] && clr_carry_o);
  assert_add_to_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_state[1] |=> dec_state[2]);
endmodule

bind mulseq_ctrl mulseq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .mbit0(mbit0),
  .dec_state(dec_state), .init_o(init_o), .load_o(load_o),
  .clr_carry_o(clr_carry_o), .shift_dec_o(shift_dec_o)
);

// File: tb/mulseq_ctrl_tb.sv
module mulseq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, cnt_zero = 1'b0, mbit0 = 1'b0;
  logic [2:0] ds_a, ds_b;
  logic ini_a, ld_a, clr_a, sh_a;
  logic ini_b, ld_b, clr_b, sh_b;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulseq_ctrl #(.ONE_HOT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .mbit0(mbit0),
    .dec_state(ds_a), .init_o(ini_a), .load_o(ld_a), .clr_carry_o(clr_a), .shift_dec_o(sh_a));
  mulseq_ctrl #(.ONE_HOT(1'b1)) dut_oh_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .mbit0(mbit0),
    .dec_state(ds_b), .init_o(ini_b), .load_o(ld_b), .clr_carry_o(clr_b), .shift_dec_o(sh_b));

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_one(input logic [2:0] ds, input logic ini, input logic ld,
                         input logic clr, input logic sh, input logic [2:0] es,
                         input string st_tag);
    logic idle, add, shf;
    idle = es[0];
    add  = es[1];
    shf  = es[2];
    chk({1'b0, ds}, {1'b0, es}, st_tag);
    chk({3'b0, ini}, {3'b0, idle & go}, "R3 init");
    chk({3'b0, ld},  {3'b0, add & mbit0}, "R4 load");
    chk({3'b0, clr}, {3'b0, (idle & go) | shf}, "R5 clr_carry");
    chk({3'b0, sh},  {3'b0, shf}, "R5 shift_dec");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_st, nxt;
    string tag;
    exp_st = 3'b001;
    @(negedge clk);
    #1;
    chk_one(ds_a, ini_a, ld_a, clr_a, sh_a, 3'b001, "R1 reset state");
    chk({3'b0, ini_a | ld_a | clr_a | sh_a}, 4'b0, "R1 reset strobes");
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 first state";
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      go       = ($urandom_range(0, 2) == 0);
      cnt_zero = ($urandom_range(0, 3) == 0);
      mbit0    = $urandom_range(0, 1) != 0;
      #1;
      chk_one(ds_a, ini_a, ld_a, clr_a, sh_a, exp_st, tag);
      chk_one(ds_b, ini_b, ld_b, clr_b, sh_b, exp_st, tag);
      chk({1'b0, ds_a}, {1'b0, ds_b}, "R7 state match");
      chk({ini_a, ld_a, clr_a, sh_a}, {ini_b, ld_b, clr_b, sh_b}, "R7 strobe match");
      if (exp_st[0]) begin
        nxt = go ? 3'b010 : 3'b001;
        tag = go ? "R3 next after start" : "R2 idle hold";
      end else if (exp_st[1]) begin
        nxt = 3'b100;
        tag = "R6 add to shift";
      end else begin
        nxt = cnt_zero ? 3'b001 : 3'b010;
        tag = "R5 shift next";
      end
      @(posedge clk);
      exp_st = nxt;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule